// File: doc/BRIEF.md
# Slave serial configuration receiver

This block takes in a configuration bitstream one bit at a time. Each bit comes on a data input and is sampled on the rising edge of a configuration clock supplied from outside. A bit is taken only when two conditions hold: the mode inputs select slave-serial operation, and the shared initialization-ready line is high. The block first takes in its own payload of `PAYLOAD_BITS` bits and runs a CRC-16 over it. It then reads a trailing 16-bit check value and compares it with that CRC. On a match it raises done. On a mismatch it raises an error flag, pulls its initialization-ready drive low and refuses further bits.

After its own payload has loaded, the block becomes a link in a daisy chain. Each later bit it accepts is copied to a registered chain output on the same rising edge, for the next device downstream. The forwarded traffic is capped at `FWD_WORDS` words of `WORD_BITS` bits each, which by default is 1,048,575 words of 32 bits. Bits beyond that cap are not passed on, and the chain output stays low.

A synchronous program input returns the receiver to its empty state. It can restart a load at any point. On a board, the mode pins are pulled up weakly, so that unconnected pins select this mode.

Top module: `serial_cfg_rx`

## Requirements
- R1: A bit is accepted only when mode_i[1:0] is 2'b11; mode_i[2] has no effect, and bits presented under any other mode_i[1:0] value are ignored.
- R2: Bits presented while init_rdy_i is low are ignored.
- R3: The first PAYLOAD_BITS accepted bits form the payload. The CRC over them uses polynomial 0x1021, starts at 0xFFFF and shifts one bit at a time, the first bit first. The next 16 accepted bits form the check value, most significant bit first.
- R4: If the check value equals the CRC, done_o goes high after the edge that takes the last check bit, and it stays high until program.
- R5: If the check value differs from the CRC, err_o goes high and init_drive_o goes low after that edge. done_o stays low, and all later bits are ignored until program.
- R6: Once done_o is high, each accepted bit appears on dout_o after the edge that takes it, and holds there until the next accepted bit. dout_o is low whenever done_o is low.
- R7: Only the first FWD_WORDS*WORD_BITS accepted bits after done are forwarded; every later accepted bit drives dout_o low.
- R8: prog high on an edge clears done, err, dout_o, the CRC and all counters, whatever the other inputs are; it wins over a bit on the same edge.
- R9: After program: done_o=0, err_o=0, dout_o=0, init_drive_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External configuration clock, rising edge active |
| prog | input | 1 | Synchronous program/restart, active high |
| mode_i | input | 3 | Mode select; slave-serial when bits 1:0 are both high |
| init_rdy_i | input | 1 | Shared initialization-ready level |
| din | input | 1 | Serial configuration data |
| dout_o | output | 1 | Daisy-chain data to the next device |
| done_o | output | 1 | Own payload loaded with a good CRC |
| err_o | output | 1 | CRC mismatch detected |
| init_drive_o | output | 1 | Drive for the initialization-ready line; low on error |

## Verification
Two events are made to fall on the same edge. In one case a program pulse lands on the edge that carries the last check bit. In the other, an accepted bit lands on the edge that completes the last permitted forwarded word. For the first collision the bench drives prog and the final correct check bit together, and then expects done_o and err_o both low and a fresh load to succeed. For the second, it expects the bit on the completing edge to reach dout_o, and every accepted bit after it to give a low output. A behavioural queue model compares all four outputs after each clock.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_CHK  = 2'd1,
        ST_FWD  = 2'd2,
        ST_FAIL = 2'd3
    } rx_state_e;

    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/cfg_crc16_acc.sv
module cfg_crc16_acc
    import cfg_rx_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  logic        en,
    input  logic        bit_i,
    output logic [15:0] crc_o
);

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)
            crc_d = CRC_SEED;
        else if (en)
            crc_d = crc_step(crc_q, bit_i);
    end

    always_ff @(posedge clk) begin
        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    // R3
    crc_hold_chk: assert property (@(posedge clk) disable iff (clr)
        !en |=> $stable(crc_q));

endmodule

// File: rtl/cfg_fwd_count.sv
module cfg_fwd_count #(
    parameter int WORD_BITS = 32,
    parameter int FWD_WORDS = 1048575
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic full_o
);

    localparam int BCW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam int WCW = $clog2(FWD_WORDS + 1);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(WORD_BITS - 1);
    localparam logic [WCW-1:0] WORD_LIM = WCW'(FWD_WORDS);

    typedef struct packed {
        logic [BCW-1:0] bits;
        logic [WCW-1:0] words;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic full;

    assign full = (cnt_q.words == WORD_LIM);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && !full) begin
            if (cnt_q.bits == BIT_LAST) begin
                cnt_d.bits  = '0;
                cnt_d.words = cnt_q.words + 1'b1;
            end else begin
                cnt_d.bits = cnt_q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign full_o = full;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (clr)
        cnt_q.words <= WORD_LIM);

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (clr)
        full |=> full_o);

endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
    import cfg_rx_pkg::*;
#(
    parameter int PAYLOAD_BITS = 64,
    parameter int WORD_BITS    = 32,
    parameter int FWD_WORDS    = 1048575
) (
    input  logic       clk,
    input  logic       prog,
    input  logic [2:0] mode_i,
    input  logic       init_rdy_i,
    input  logic       din,
    output logic       dout_o,
    output logic       done_o,
    output logic       err_o,
    output logic       init_drive_o
);

    localparam int CW = $clog2((PAYLOAD_BITS > CRC_W) ? PAYLOAD_BITS : CRC_W);
    localparam logic [CW-1:0] PAY_LAST = CW'(PAYLOAD_BITS - 1);
    localparam logic [CW-1:0] CHK_LAST = CW'(CRC_W - 1);

    typedef struct packed {
        rx_state_e   state;
        logic [CW-1:0] cnt;
        logic [15:0] rx;
        logic        done;
        logic        err;
        logic        dout;
    } regs_t;

    regs_t r_d, r_q;

    logic        mode_ok;
    logic        take;
    logic        crc_en;
    logic        fwd_en;
    logic        fwd_full;
    logic [15:0] crc_val;
    logic        unused_mode_m2;

    assign unused_mode_m2 = mode_i[2];
    assign mode_ok = mode_i[0] & mode_i[1];
    assign take    = mode_ok & init_rdy_i & ~r_q.err & ~prog;
    assign crc_en  = take & (r_q.state == ST_LOAD);
    assign fwd_en  = take & (r_q.state == ST_FWD);

    cfg_crc16_acc i_crc (
        .clk   (clk),
        .clr   (prog),
        .en    (crc_en),
        .bit_i (din),
        .crc_o (crc_val)
    );

    cfg_fwd_count #(
        .WORD_BITS (WORD_BITS),
        .FWD_WORDS (FWD_WORDS)
    ) i_fwd (
        .clk    (clk),
        .clr    (prog),
        .en     (fwd_en),
        .full_o (fwd_full)
    );

    always_comb begin
        r_d = r_q;
        if (prog) begin
            r_d = '0;
            r_d.state = ST_LOAD;
        end else if (take) begin
            unique case (r_q.state)
                ST_LOAD: begin
                    if (r_q.cnt == PAY_LAST) begin
                        r_d.cnt   = '0;
                        r_d.state = ST_CHK;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_CHK: begin
                    r_d.rx = {r_q.rx[14:0], din};
                    if (r_q.cnt == CHK_LAST) begin
                        r_d.cnt = '0;
                        if ({r_q.rx[14:0], din} == crc_val) begin
                            r_d.done  = 1'b1;
                            r_d.state = ST_FWD;
                        end else begin
                            r_d.err   = 1'b1;
                            r_d.state = ST_FAIL;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_FWD: begin
                    r_d.dout = fwd_full ? 1'b0 : din;
                end
                default: begin
                    r_d = r_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign dout_o       = r_q.dout;
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;
    assign init_drive_o = ~r_q.err;

    // R5
    no_done_err_chk: assert property (@(posedge clk) disable iff (prog)
        !(r_q.done && r_q.err));

    // R6
    dout_quiet_chk: assert property (@(posedge clk) disable iff (prog)
        !r_q.done |-> !dout_o);

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (prog)
        r_q.done |=> done_o);

    // R2
    gate_chk: assert property (@(posedge clk) disable iff (prog)
        !init_rdy_i |=> ($stable(r_q.cnt) && $stable(r_q.state) && $stable(dout_o)));

    // R5
    fail_freeze_chk: assert property (@(posedge clk) disable iff (prog)
        r_q.err |=> (err_o && !init_drive_o && $stable(r_q.state)));

    // R8
    prog_clear_chk: assert property (@(posedge clk)
        prog |=> (!done_o && !err_o && !dout_o && init_drive_o));

endmodule

// File: tb/test_serial_cfg_rx.sv
module test_serial_cfg_rx;

    localparam int PB = 24;
    localparam int WB = 8;
    localparam int FW = 3;
    localparam int LIM = WB * FW;

    logic       clk = 1'b0;
    logic       prog = 1'b1;
    logic [2:0] mode = 3'b111;
    logic       init_in = 1'b0;
    logic       din = 1'b0;
    logic       dout, done, err, idrv;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // behavioural model
    int   m_ph = 0;  // 0 payload, 1 check, 2 forward, 3 fail
    bit   m_pay[$];
    int   m_nchk = 0;
    logic [15:0] m_rx = '0;
    int   m_nfwd = 0;
    logic e_done = 0, e_err = 0, e_dout = 0;

    always #5 clk = ~clk;

    serial_cfg_rx #(
        .PAYLOAD_BITS (PB),
        .WORD_BITS    (WB),
        .FWD_WORDS    (FW)
    ) i_serial_cfg_rx (
        .clk          (clk),
        .prog         (prog),
        .mode_i       (mode),
        .init_rdy_i   (init_in),
        .din          (din),
        .dout_o       (dout),
        .done_o       (done),
        .err_o        (err),
        .init_drive_o (idrv)
    );

    function automatic logic [15:0] ref_crc();
        int c = 16'hFFFF;
        foreach (m_pay[k]) begin
            int top = (c >> 15) & 1;
            c = (c << 1) & 16'hFFFF;
            if ((top ^ int'(m_pay[k])) != 0) c = c ^ 16'h1021;
        end
        return 16'(c);
    endfunction

    task automatic model(input logic [2:0] m, input logic ir, input logic d, input logic p);
        if (p) begin
            m_ph = 0; m_pay.delete(); m_nchk = 0; m_rx = '0; m_nfwd = 0;
            e_done = 0; e_err = 0; e_dout = 0;
        end else if (m[0] && m[1] && ir && !e_err) begin
            if (m_ph == 0) begin
                m_pay.push_back(d);
                if (m_pay.size() == PB) m_ph = 1;
            end else if (m_ph == 1) begin
                m_rx = {m_rx[14:0], d};
                m_nchk++;
                if (m_nchk == 16) begin
                    if (m_rx == ref_crc()) begin e_done = 1; m_ph = 2; end
                    else begin e_err = 1; m_ph = 3; end
                end
            end else if (m_ph == 2) begin
                if (m_nfwd < LIM) begin e_dout = d; m_nfwd++; end
                else e_dout = 0;
            end
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if ({done, err, dout, idrv} !== {e_done, e_err, e_dout, ~e_err}) begin
            fails++;
            $display("FAIL %s done/err/dout/idrv actual=%b%b%b%b expected=%b%b%b%b",
                     tag, done, err, dout, idrv, e_done, e_err, e_dout, ~e_err);
        end
    endtask

    task automatic cyc(input logic [2:0] m, input logic ir, input logic d, input logic p,
                       input string tag);
        mode = m; init_in = ir; din = d; prog = p;
        @(posedge clk);
        model(m, ir, d, p);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic bit pat(input int i, input int seed);
        return bit'(((i * 7 + seed) % 5) < 2);
    endfunction

    // loads a payload with interleaved ignored cycles; leaves crc for the caller
    task automatic load_payload(input int seed);
        for (int i = 0; i < PB; i++) begin
            if (i % 5 == 2) cyc(3'b101, 1'b1, ~pat(i, seed), 1'b0, "R1");
            if (i % 5 == 4) cyc(3'b010, 1'b1, ~pat(i, seed), 1'b0, "R1");
            if (i % 7 == 3) cyc(3'b111, 1'b0, ~pat(i, seed), 1'b0, "R2");
            cyc(i[0] ? 3'b111 : 3'b011, 1'b1, pat(i, seed), 1'b0, "R3");
        end
    endtask

    task automatic send_check(input logic [15:0] v, input int nbits, input string tag);
        for (int b = 0; b < nbits; b++)
            cyc(3'b011, 1'b1, v[15 - b], 1'b0, tag);
    endtask

    initial begin
        logic [15:0] good;
        @(negedge clk);
        cyc(3'b111, 1'b1, 1'b1, 1'b1, "R9");
        cyc(3'b111, 1'b1, 1'b0, 1'b1, "R9");
        check("R9", done, 1'b0, "done after program");
        check("R9", idrv, 1'b1, "init drive after program");
        check("R9", dout, 1'b0, "dout after program");

        // good load, forwarding up to and past the limit
        load_payload(3);
        good = ref_crc();
        send_check(good, 15, "R3");
        check("R4", done, 1'b0, "done before last check bit");
        send_check(good << 15, 1, "R4");
        check("R4", done, 1'b1, "done on match");
        check("R4", err, 1'b0, "err on match");
        for (int i = 0; i < LIM + 10; i++) begin
            if (i % 6 == 5) cyc(3'b111, 1'b0, 1'b1, 1'b0, "R2");
            if (i % 9 == 4) cyc(3'b000, 1'b1, 1'b1, 1'b0, "R1");
            cyc(3'b111, 1'b1, bit'(i % 3 == 0 || i == LIM - 1), 1'b0, i < LIM ? "R6" : "R7");
            if (i == LIM - 1) check("R7", dout, 1'b1, "last permitted bit forwarded");
        end
        check("R7", dout, 1'b0, "dout past limit");
        check("R4", done, 1'b1, "done holds");

        // bad check value
        cyc(3'b111, 1'b1, 1'b1, 1'b1, "R8");
        load_payload(1);
        good = ref_crc();
        send_check(good ^ 16'h0100, 16, "R5");
        check("R5", err, 1'b1, "err on mismatch");
        check("R5", idrv, 1'b0, "init drive on mismatch");
        check("R5", done, 1'b0, "done on mismatch");
        for (int i = 0; i < 12; i++) cyc(3'b111, 1'b1, 1'b1, 1'b0, "R5");
        check("R5", dout, 1'b0, "dout after mismatch");

        // program colliding with final check bit
        cyc(3'b111, 1'b1, 1'b0, 1'b1, "R8");
        load_payload(4);
        good = ref_crc();
        send_check(good, 15, "R3");
        cyc(3'b011, 1'b1, good[0], 1'b1, "R8");
        check("R8", done, 1'b0, "done after colliding program");
        check("R8", err, 1'b0, "err after colliding program");

        // fresh load after collision, short forwarding
        load_payload(2);
        send_check(ref_crc(), 16, "R4");
        check("R4", done, 1'b1, "done after reload");
        cyc(3'b111, 1'b1, 1'b1, 1'b0, "R6");
        check("R6", dout, 1'b1, "forward one");
        cyc(3'b111, 1'b0, 1'b0, 1'b0, "R2");
        check("R6", dout, 1'b1, "dout holds on ignored bit");
        cyc(3'b011, 1'b1, 1'b0, 1'b0, "R6");
        check("R6", dout, 1'b0, "forward zero");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule